// File: doc/BRIEF.md
# Flash Program/Erase Array Controller

This block owns a small byte-wide flash array and applies the two operations flash permits: programming, which can only clear bits, and sector erase, which returns one whole sector to all ones. A command port takes a program or erase request with a byte address. Programming takes its data from a page buffer that is loaded beforehand through its own write port. The buffer size can be chosen at run time as a half page or a full page, in a 1:2 ratio. A registered read port returns stored bytes, and a busy flag covers each operation.

The array is scaled down so that it can be simulated, and it keeps the 1:64 ratio between small and large sectors. With the default parameters a small sector is 4 bytes, a large sector is 256 bytes, the array is 2048 bytes, and the two buffer sizes are 16 and 32 bytes. Sector boundaries are resolved from a run-time map mode:
- **Uniform:** every sector is large.
- **One-end hybrid:** 32 small sectors are grouped at the bottom or at the top of the address space.
- **Split hybrid:** 16 small sectors sit at each end.

The large sector that borders a small-sector group is cut short and covers only the bytes outside that group.

The controller is a four-state machine:
- **IDLE** goes to PROGRAM or ERASE when it accepts a command.
- **PROGRAM** writes one byte per cycle and goes to HOLD when the last byte is written, or straight to IDLE if the hold count is zero.
- **ERASE** writes one byte per cycle across the sector and leaves the same way on its last byte.
- **HOLD** counts down the programmed hold cycles and then returns to IDLE.

Top module: `fpe_ctrl`

## Requirements
- R1: After reset every array byte reads 0xFF, `busy` is 0 and `cmd_err` is 0.
- R2: A program leaves each target byte equal to its old value ANDed with the buffer byte, so bits only go from 1 to 0.
- R3: The page size is 16 bytes when `cfg_buf_big`=0 and 32 bytes when it is 1. Buffer byte j goes to the address whose bits above the page offset equal those of `cmd_addr`, with a page offset of (offset of `cmd_addr` + j) modulo the page size, so a program wraps inside its page.
- R4: A program with `cmd_len` of 0 or greater than the page size is rejected: `cmd_err` pulses for one cycle, `busy` stays 0 and the array is unchanged.
- R5: `cfg_map` selects the mode: 0 is uniform, 1 is one-end hybrid, 2 is split hybrid, and 3 behaves as uniform. In uniform mode an erase sets the 256-byte aligned sector that holds `cmd_addr` to 0xFF and nothing else.
- R6: In one-end hybrid mode, bytes 0..127 (when `cfg_small_top`=0) or 1920..2047 (when it is 1) form 4-byte aligned sectors. The large sector next to that group covers only bytes 128..255 or 1792..1919 respectively.
- R7: In split hybrid mode, bytes 0..63 and 1984..2047 form 4-byte sectors. The large sectors next to them cover 64..255 and 1792..1983.
- R8: From the edge that accepts a command, `busy` stays high for N + H cycles and then falls. N is `cmd_len` for a program or the sector's byte count for an erase, and H is the `cfg_hold` value captured with the command.
- R9: A command presented while `busy` is high is rejected. `cmd_err` is high in the following cycle, and neither the array nor the length of the busy period changes.
- R10: Buffer writes made while `busy` is high are ignored.
- R11: `rd_data` shows the byte at `rd_addr` one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_map | input | 2 | Sector map mode |
| cfg_small_top | input | 1 | One-end hybrid: 1 puts the small sectors at the top |
| cfg_buf_big | input | 1 | 1 selects the full page size, 0 the half page |
| cfg_hold | input | 8 | Extra busy cycles after each operation |
| cmd_valid | input | 1 | Command request |
| cmd_erase | input | 1 | 1 = sector erase, 0 = program |
| cmd_addr | input | 11 | Byte address of the command |
| cmd_len | input | 6 | Program byte count |
| buf_we | input | 1 | Page buffer write enable |
| buf_idx | input | 5 | Page buffer byte index |
| buf_wdata | input | 8 | Page buffer write data |
| rd_addr | input | 11 | Read address |
| rd_data | output | 8 | Read data, one cycle after the address |
| busy | output | 1 | Operation in progress |
| cmd_err | output | 1 | One-cycle pulse on a rejected command |

## Verification
For each of the five map settings, the bench first zeroes the whole array. It then erases at addresses on both sides of every small/large border and at both array ends, and reads back all 2048 bytes. A design with an off-by-one border, a large sector that is not cut short, or a wrong end for the small group would leave zeros where ones belong, or wipe a neighbour. Program tests cover offsets that wrap in both page sizes, so a design that spills into the next page or uses the wrong size writes the wrong bytes. They also cover lengths 0 and page size + 1, repeated programs that would expose an overwrite in place of an AND, busy-period counts with and without hold cycles, and commands and buffer writes issued while busy, which a faulty design would act on.

// File: rtl/fpe_pkg.sv
package fpe_pkg;
    localparam int FPE_DW        = 8;
    localparam int FPE_SMALL_B   = 4;
    localparam int FPE_LARGE_B   = 256;
    localparam int FPE_N_LARGE   = 8;
    localparam int FPE_SMALL_CNT = 32;
    localparam int FPE_BUF_MAX   = 32;
    localparam int FPE_HOLD_W    = 8;

    localparam logic [1:0] MAP_UNIFORM   = 2'd0;
    localparam logic [1:0] MAP_ONE_END   = 2'd1;
    localparam logic [1:0] MAP_BOTH_ENDS = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PROG  = 2'd1,
        ST_ERASE = 2'd2,
        ST_HOLD  = 2'd3
    } fpe_state_e;
endpackage

// File: rtl/fpe_sector_map.sv
module fpe_sector_map
    import fpe_pkg::*;
#(
    parameter int AW        = 11,
    parameter int MEM_B     = 2048,
    parameter int SMALL_B   = 4,
    parameter int LARGE_B   = 256,
    parameter int SMALL_CNT = 32
) (
    input  logic [1:0]    map_mode,
    input  logic          small_top,
    input  logic [AW-1:0] addr,
    output logic [AW-1:0] base,
    output logic [AW-1:0] last
);
    localparam int SPAN = SMALL_CNT * SMALL_B;

    always_comb begin
        int a;
        int lo;
        int hi;
        int hs;
        int b;
        int l;
        a  = int'(addr);
        lo = 0;
        hi = 0;
        if (map_mode == MAP_ONE_END) begin
            if (small_top) hi = SPAN;
            else           lo = SPAN;
        end else if (map_mode == MAP_BOTH_ENDS) begin
            lo = SPAN / 2;
            hi = SPAN / 2;
        end
        hs = MEM_B - hi;
        if (a < lo || a >= hs) begin
            b = a - (a % SMALL_B);
            l = b + SMALL_B - 1;
        end else begin
            b = a - (a % LARGE_B);
            l = b + LARGE_B - 1;
            if (b < lo)  b = lo;
            if (l >= hs) l = hs - 1;
        end
        // R5
        sector_span_chk: assert (l >= b && (l - b) < LARGE_B && a >= b && a <= l);
        base = AW'(b);
        last = AW'(l);
    end
endmodule

// File: rtl/fpe_page_buf.sv
module fpe_page_buf #(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] ridx,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[widx] <= wdata;
    end

    assign rdata = store[ridx];
endmodule

// File: rtl/fpe_array.sv
module fpe_array #(
    parameter int DEPTH = 2048,
    parameter int DW    = 8,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_and,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] chk_addr_q;
    logic [DW-1:0] chk_old_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
            rd_data    <= '1;
            chk_addr_q <= '0;
            chk_old_q  <= '1;
        end else begin
            if (wr_en) begin
                mem[wr_addr] <= wr_and ? (mem[wr_addr] & wr_data) : wr_data;
                chk_addr_q   <= wr_addr;
                chk_old_q    <= mem[wr_addr];
            end
            rd_data <= mem[rd_addr];
        end
    end

    // R2
    prog_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_and) |=> ((mem[chk_addr_q] & ~chk_old_q) == '0));
endmodule

// File: rtl/fpe_ctrl.sv
module fpe_ctrl
    import fpe_pkg::*;
#(
    parameter int DW        = FPE_DW,
    parameter int SMALL_B   = FPE_SMALL_B,
    parameter int LARGE_B   = FPE_LARGE_B,
    parameter int N_LARGE   = FPE_N_LARGE,
    parameter int SMALL_CNT = FPE_SMALL_CNT,
    parameter int BUF_MAX   = FPE_BUF_MAX,
    parameter int HOLD_W    = FPE_HOLD_W,
    localparam int MEM_B    = N_LARGE * LARGE_B,
    localparam int AW       = $clog2(MEM_B),
    localparam int BIW      = $clog2(BUF_MAX),
    localparam int LW       = BIW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_map,
    input  logic              cfg_small_top,
    input  logic              cfg_buf_big,
    input  logic [HOLD_W-1:0] cfg_hold,
    input  logic              cmd_valid,
    input  logic              cmd_erase,
    input  logic [AW-1:0]     cmd_addr,
    input  logic [LW-1:0]     cmd_len,
    input  logic              buf_we,
    input  logic [BIW-1:0]    buf_idx,
    input  logic [DW-1:0]     buf_wdata,
    input  logic [AW-1:0]     rd_addr,
    output logic [DW-1:0]     rd_data,
    output logic              busy,
    output logic              cmd_err
);
    fpe_state_e        state_q, state_d;
    logic [AW-1:0]     pos_q, last_q, page_base_q, off_q, pgmask_q;
    logic [LW-1:0]     idx_q, cnt_q;
    logic [HOLD_W-1:0] hold_q;
    logic              err_d, go, len_ok;
    logic [AW-1:0]     pgmask, map_base, map_last, prog_addr;
    logic [LW-1:0]     pg_len;
    logic              arr_we, arr_and;
    logic [AW-1:0]     arr_addr;
    logic [DW-1:0]     arr_wdata, buf_rdata;

    assign pgmask    = cfg_buf_big ? AW'(BUF_MAX - 1) : AW'(BUF_MAX / 2 - 1);
    assign pg_len    = cfg_buf_big ? LW'(BUF_MAX) : LW'(BUF_MAX / 2);
    assign len_ok    = (cmd_len != '0) && (cmd_len <= pg_len);
    assign go        = cmd_valid && (state_q == ST_IDLE) && (cmd_erase || len_ok);
    assign prog_addr = page_base_q | ((off_q + AW'(idx_q)) & pgmask_q);
    assign busy      = (state_q != ST_IDLE);

    fpe_sector_map #(.AW(AW), .MEM_B(MEM_B), .SMALL_B(SMALL_B),
                     .LARGE_B(LARGE_B), .SMALL_CNT(SMALL_CNT)) u_map (
        .map_mode(cfg_map), .small_top(cfg_small_top), .addr(cmd_addr),
        .base(map_base), .last(map_last));

    fpe_page_buf #(.DEPTH(BUF_MAX), .DW(DW)) u_buf (
        .clk(clk), .we(buf_we && (state_q == ST_IDLE)), .widx(buf_idx),
        .wdata(buf_wdata), .ridx(idx_q[BIW-1:0]), .rdata(buf_rdata));

    fpe_array #(.DEPTH(MEM_B), .DW(DW)) u_arr (
        .clk(clk), .rst_n(rst_n), .wr_en(arr_we), .wr_and(arr_and),
        .wr_addr(arr_addr), .wr_data(arr_wdata), .rd_addr(rd_addr),
        .rd_data(rd_data));

    // next state and array controls
    always_comb begin
        state_d   = state_q;
        err_d     = 1'b0;
        arr_we    = 1'b0;
        arr_and   = 1'b0;
        arr_addr  = pos_q;
        arr_wdata = '1;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_valid) begin
                    if (cmd_erase)   state_d = ST_ERASE;
                    else if (len_ok) state_d = ST_PROG;
                    else             err_d   = 1'b1;
                end
            end
            ST_PROG: begin
                arr_we    = 1'b1;
                arr_and   = 1'b1;
                arr_addr  = prog_addr;
                arr_wdata = buf_rdata;
                if (idx_q == cnt_q - 1'b1)
                    state_d = (hold_q == '0) ? ST_IDLE : ST_HOLD;
            end
            ST_ERASE: begin
                arr_we = 1'b1;
                if (pos_q == last_q)
                    state_d = (hold_q == '0) ? ST_IDLE : ST_HOLD;
            end
            ST_HOLD: begin
                if (hold_q == HOLD_W'(1)) state_d = ST_IDLE;
            end
        endcase
        if (cmd_valid && state_q != ST_IDLE) err_d = 1'b1;
    end

    // state register and operation context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            cmd_err     <= 1'b0;
            pos_q       <= '0;
            last_q      <= '0;
            page_base_q <= '0;
            off_q       <= '0;
            pgmask_q    <= '0;
            idx_q       <= '0;
            cnt_q       <= '0;
            hold_q      <= '0;
        end else begin
            state_q <= state_d;
            cmd_err <= err_d;
            if (go) begin
                pos_q       <= map_base;
                last_q      <= map_last;
                page_base_q <= cmd_addr & ~pgmask;
                off_q       <= cmd_addr & pgmask;
                pgmask_q    <= pgmask;
                idx_q       <= '0;
                cnt_q       <= cmd_len;
                hold_q      <= cfg_hold;
            end else if (state_q == ST_PROG) begin
                idx_q <= idx_q + 1'b1;
            end else if (state_q == ST_ERASE) begin
                pos_q <= pos_q + 1'b1;
            end else if (state_q == ST_HOLD) begin
                hold_q <= hold_q - 1'b1;
            end
        end
    end

    // R3
    page_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROG) |-> ((arr_addr & ~pgmask_q) == page_base_q));
    // R4
    bad_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && !cmd_erase && cmd_len == '0) |=> (cmd_err && !busy));
    // R9
    busy_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && busy) |=> cmd_err);
    // R8
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_valid));
endmodule

// File: tb/fpe_ctrl_bench.sv
module fpe_ctrl_bench;
    localparam int MEM = 2048;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cfg_map = 2'd0;
    logic       cfg_small_top = 1'b0;
    logic       cfg_buf_big = 1'b1;
    logic [7:0] cfg_hold = 8'd0;
    logic       cmd_valid = 1'b0;
    logic       cmd_erase = 1'b0;
    logic [10:0] cmd_addr = '0;
    logic [5:0] cmd_len = '0;
    logic       buf_we = 1'b0;
    logic [4:0] buf_idx = '0;
    logic [7:0] buf_wdata = '0;
    logic [10:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       busy, cmd_err;

    int checks = 0;
    int fails  = 0;
    logic [7:0] model [MEM];
    logic [7:0] bufm  [32];

    always #2.5 clk = ~clk;

    fpe_ctrl u_fpe_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_map(cfg_map), .cfg_small_top(cfg_small_top),
        .cfg_buf_big(cfg_buf_big), .cfg_hold(cfg_hold), .cmd_valid(cmd_valid),
        .cmd_erase(cmd_erase), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
        .buf_we(buf_we), .buf_idx(buf_idx), .buf_wdata(buf_wdata),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .cmd_err(cmd_err));

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int sec_id(input int a);
        int lo = 0;
        int hi = 0;
        if (cfg_map == 2'd1) begin
            if (cfg_small_top) hi = 128; else lo = 128;
        end else if (cfg_map == 2'd2) begin
            lo = 64; hi = 64;
        end
        if (a < lo) return a / 4;
        if (a >= MEM - hi) return 100000 + a / 4;
        return 200000 + a / 256;
    endfunction

    task automatic wr_buf(input int idx, input int val);
        buf_we = 1'b1; buf_idx = 5'(idx); buf_wdata = 8'(val);
        @(negedge clk);
        buf_we = 1'b0;
        if (!busy) bufm[idx] = 8'(val);
    endtask

    task automatic run_cmd(input bit er, input int addr, input int len, output int n);
        cmd_valid = 1'b1; cmd_erase = er; cmd_addr = 11'(addr); cmd_len = 6'(len);
        @(negedge clk);
        cmd_valid = 1'b0;
        n = 0;
        while (busy) begin n++; @(negedge clk); end
    endtask

    task automatic do_prog(input string req, input int addr, input int len);
        int pg = cfg_buf_big ? 32 : 16;
        int n;
        int base = addr - (addr % pg);
        for (int j = 0; j < len; j++) begin
            int t = base + ((addr % pg + j) % pg);
            model[t] = model[t] & bufm[j];
        end
        run_cmd(1'b0, addr, len, n);
        check(req, n, len + int'(cfg_hold));
    endtask

    task automatic do_erase(input string req, input int addr);
        int id = sec_id(addr);
        int cnt = 0;
        int n;
        for (int a = 0; a < MEM; a++)
            if (sec_id(a) == id) begin model[a] = 8'hFF; cnt++; end
        run_cmd(1'b1, addr, 0, n);
        check({req, " R8"}, n, cnt + int'(cfg_hold));
    endtask

    task automatic sweep(input string req);
        for (int a = 0; a < MEM; a++) begin
            rd_addr = 11'(a);
            @(negedge clk);
            check({req, " R11"}, int'(rd_data), int'(model[a]));
        end
    endtask

    task automatic zero_all();
        cfg_buf_big = 1'b1;
        for (int j = 0; j < 32; j++) wr_buf(j, 0);
        for (int p = 0; p < MEM / 32; p++) do_prog("R2", p * 32, 32);
    endtask

    initial begin
        #750000;
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int n;
        for (int a = 0; a < MEM; a++) model[a] = 8'hFF;
        for (int j = 0; j < 32; j++) bufm[j] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 busy", int'(busy), 0);
        check("R1 err", int'(cmd_err), 0);
        sweep("R1");

        // R2 AND behaviour, full page
        for (int j = 0; j < 32; j++) wr_buf(j, 8'hF0 ^ j);
        do_prog("R2 R8", 0, 32);
        for (int j = 0; j < 32; j++) wr_buf(j, 8'h3C);
        do_prog("R2 R8", 0, 32);
        // R3 wrap in small page and in big page
        cfg_buf_big = 1'b0;
        for (int j = 0; j < 32; j++) wr_buf(j, 8'h80 | j);
        do_prog("R3", 64 + 12, 8);
        cfg_buf_big = 1'b1;
        do_prog("R3", 320 + 27, 20);
        // R4 bad lengths
        cfg_buf_big = 1'b0;
        run_cmd(1'b0, 500, 17, n);
        check("R4 len17 busy", n, 0);
        check("R4 len17 err", int'(cmd_err), 1);
        run_cmd(1'b0, 500, 0, n);
        check("R4 len0 busy", n, 0);
        check("R4 len0 err", int'(cmd_err), 1);
        cfg_buf_big = 1'b1;
        // R8 hold cycles
        cfg_hold = 8'd5;
        do_prog("R8 hold", 700, 3);
        do_erase("R8 hold", 2);
        cfg_hold = 8'd0;
        // R9 command during busy
        do_prog("R2", 1024, 32);
        cmd_valid = 1'b1; cmd_erase = 1'b1; cmd_addr = 11'd1024;
        @(negedge clk);
        check("R9 busy", int'(busy), 1);
        cmd_erase = 1'b0; cmd_addr = 11'd1500; cmd_len = 6'd1;
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R9 err", int'(cmd_err), 1);
        // R10 buffer write while busy
        wr_buf(0, 8'h00);
        n = 2;
        while (busy) begin n++; @(negedge clk); end
        check("R9 busy len", n, 256);
        for (int a = 1024; a < 1280; a++) model[a] = 8'hFF;
        bufm[0] = 8'h80;
        do_prog("R10", 1600, 1);
        sweep("R2 R3 R4 R9 R10");

        // R5 R6 R7 map sweeps
        for (int m = 0; m < 5; m++) begin
            cfg_map = (m == 4) ? 2'd3 : (m >= 3 ? 2'd2 : 2'(m > 0));
            cfg_small_top = (m == 2);
            zero_all();
            do_erase("R5 R6 R7", 0);
            do_erase("R5 R6 R7", 65);
            do_erase("R5 R6 R7", 130);
            do_erase("R5 R6 R7", 700);
            do_erase("R5 R6 R7", 1919);
            do_erase("R5 R6 R7", 1986);
            do_erase("R5 R6 R7", 2047);
            sweep(m == 0 || m == 4 ? "R5" : (m == 3 ? "R7" : "R6"));
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule